// File: doc/BRIEF.md
# Timer-Driven Converter Acquisition Sequencer

This block runs one complete converter acquisition each time a periodic timer output rises, so the host does not have to step through it. On a rising tick it pulses a convert-start strobe that makes two four-channel simultaneous-sampling ADCs capture all eight inputs together. It then writes four queued DAC values over a small 16-word register bus and pulses one load strobe shared by all DAC channels. Next it waits until neither ADC reports busy. It reads the eight result words in a fixed order and hands each word to a sample buffer write port. A single ready pulse follows the last read.

The register bus uses a 4-bit word address. The upper two address bits select the device, and the chip selects are decoded from those bits. A tick that arrives while an acquisition is in progress is not queued: it sets a sticky overrun flag. If the busy lines do not clear within a programmable number of clocks, the acquisition is abandoned and a sticky timeout flag is set. A single clear input resets both flags.

Top module: `acq_sequencer`

## Requirements
- R1: A rising edge of `tick_i` seen while idle gives exactly one single-cycle `conv_start_o` pulse, in the clock cycle after the sampling edge. A tick held high does not start a second acquisition.
- R2: In the four cycles after `conv_start_o`, `wr_stb_o` is high with `addr_o` = 12, 13, 14, 15 in that order. `wr_data_o` carries DAC slot 0..3 of `dac_vals_i` (slot i = bits i*16 +: 16). In the cycle after the last write, one `dac_load_o` pulse follows. The whole refresh ends 6 clocks after the tick, well inside a 1.2 µs budget.
- R3: The selects are decoded from the upper two address bits. `sel_adc_a_o` is high for addr[3:2] = 01 (words 4–7). `sel_adc_b_o` is high for 10 (words 8–11). `sel_dac_o` is high for 11 (words 12–15), but only while a read or write strobe is high. Words 0–3 select nothing, and `addr_o` is 0 whenever no strobe is active.
- R4: The readout starts only after both `busy_a_i` and `busy_b_i` are low at a clock edge. The first read strobe appears in the cycle after that edge. While either busy line is high, no read is issued.
- R5: The block makes eight reads, one strobe per word, at addresses 4 through 11 in order. In each read cycle, `buf_we_o` is high, `buf_idx_o` = address − 4 and `buf_data_o` equals `rd_data_i`.
- R6: `ready_o` pulses for one cycle, in the cycle right after the read of address 11. It pulses only for acquisitions that completed their readout.
- R7: A rising tick while an acquisition is in progress starts nothing. It sets `overrun_o`, which stays set until `flag_clr_i` is high at a clock edge.
- R8: The block counts the cycles spent waiting with a busy line high. If the busy lines have not both cleared within `tmo_limit_i` (≥ 1) such cycles, the acquisition ends with no reads and no ready pulse. `tmo_err_o` is set in the cycle after the last allowed wait cycle and stays set until `flag_clr_i`.
- R9: In reset and while idle, all strobes, selects, `ready_o` and both flags are low, and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic timer output; rising edge starts an acquisition |
| busy_a_i | input | 1 | Busy from ADC A (channels 1–4) |
| busy_b_i | input | 1 | Busy from ADC B (channels 5–8) |
| rd_data_i | input | 16 | Read data returned by the addressed ADC |
| dac_vals_i | input | 64 | Four queued DAC values, slot i at bits i*16 +: 16 |
| tmo_limit_i | input | 16 | Busy-wait limit in clocks |
| flag_clr_i | input | 1 | Clears the overrun and timeout flags |
| conv_start_o | output | 1 | Convert-start pulse to both ADCs |
| sel_adc_a_o | output | 1 | Chip select, ADC A |
| sel_adc_b_o | output | 1 | Chip select, ADC B |
| sel_dac_o | output | 1 | Chip select, DAC |
| rd_stb_o | output | 1 | Bus read strobe |
| wr_stb_o | output | 1 | Bus write strobe |
| addr_o | output | 4 | Bus word address |
| wr_data_o | output | 16 | Bus write data |
| dac_load_o | output | 1 | Common DAC load pulse |
| buf_we_o | output | 1 | Sample buffer write enable |
| buf_idx_o | output | 3 | Sample buffer slot |
| buf_data_o | output | 16 | Sample buffer write data |
| ready_o | output | 1 | Acquisition complete pulse |
| overrun_o | output | 1 | Sticky tick-overrun flag |
| tmo_err_o | output | 1 | Sticky busy-timeout flag |

## Verification
The hardest case to reach from the ports is the timeout boundary. The busy lines must clear in the very last wait cycle the limit allows, and the run must then be compared with one where they stay high a single cycle longer. The bench sets the limit to 4 and counts from the tick. In one run it releases busy exactly in the fourth wait cycle and expects normal readout. In another it holds busy and expects the error in the next cycle with nothing read. Overrun is reached by raising a second tick while the block waits on a busy line that the bench deliberately holds. The bench also releases the two busy lines in both orders, which shows that one converter alone never opens the readout.

// File: rtl/acq_pkg.sv
package acq_pkg;

  localparam int unsigned BUS_AW   = 4;
  localparam int unsigned ADC_BASE = 4;
  localparam int unsigned DAC_BASE = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DACW,
    ST_LOAD,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } acq_state_t;

  typedef struct packed {
    logic adc_a;
    logic adc_b;
    logic dac;
  } sel_t;

  // word address of the k-th ADC result register
  function automatic logic [BUS_AW-1:0] adc_word(input int unsigned k);
    return BUS_AW'(ADC_BASE + k);
  endfunction

  // word address of the i-th DAC channel register
  function automatic logic [BUS_AW-1:0] dac_word(input int unsigned i);
    return BUS_AW'(DAC_BASE + i);
  endfunction

  // device select from the two upper address bits
  function automatic sel_t decode_word(input logic [BUS_AW-1:0] a, input logic strobe);
    sel_t s;
    s.adc_a = (a[3:2] == 2'b01);
    s.adc_b = (a[3:2] == 2'b10);
    s.dac   = (a[3:2] == 2'b11) && strobe;
    return s;
  endfunction

endpackage

// File: rtl/acq_decode.sv
module acq_decode
  import acq_pkg::*;
(
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              sel_adc_a_o,
  output logic              sel_adc_b_o,
  output logic              sel_dac_o
);

  sel_t sel;

  always_comb begin
    sel         = decode_word(addr_i, rd_i | wr_i);
    sel_adc_a_o = sel.adc_a;
    sel_adc_b_o = sel.adc_b;
    sel_dac_o   = sel.dac;
  end

endmodule

// File: rtl/acq_busy_timer.sv
module acq_busy_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_a_i,
  input  logic             busy_b_i,
  input  logic             wait_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             conv_done_o,
  output logic             tmo_hit_o
);

  logic [TMO_W-1:0] wait_cnt;

  // conversion finished only when neither converter is busy
  assign conv_done_o = ~(busy_a_i | busy_b_i);

  // last allowed wait cycle spent still busy
  assign tmo_hit_o = wait_i && !conv_done_o && (wait_cnt == limit_i - TMO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !wait_i) wait_cnt <= '0;
    else                   wait_cnt <= wait_cnt + TMO_W'(1);
  end

endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DAC_CH = 4,
  parameter int unsigned ADC_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic                     conv_done_i,
  input  logic                     tmo_hit_i,
  input  logic                     flag_clr_i,
  input  logic [DAC_CH*DATA_W-1:0] dac_vals_i,
  output logic                     conv_start_o,
  output logic                     wr_stb_o,
  output logic                     rd_stb_o,
  output logic [BUS_AW-1:0]        addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic                     dac_load_o,
  output logic [$clog2(ADC_CH)-1:0] buf_idx_o,
  output logic                     ready_o,
  output logic                     wait_o,
  output logic                     overrun_o,
  output logic                     tmo_err_o
);

  localparam int unsigned MAX_CH = (ADC_CH > DAC_CH) ? ADC_CH : DAC_CH;
  localparam int unsigned IDX_W  = $clog2(MAX_CH);
  localparam int unsigned DAC_IW = $clog2(DAC_CH);
  localparam int unsigned ADC_IW = $clog2(ADC_CH);

  logic [DATA_W-1:0] dac_arr [DAC_CH];

  for (genvar g = 0; g < DAC_CH; g++) begin : g_dac_slot
    assign dac_arr[g] = dac_vals_i[g*DATA_W +: DATA_W];
  end

  acq_state_t       state, state_nx;
  logic [IDX_W-1:0] idx, idx_nx;
  logic             tick_q;
  logic             tick_rise;
  logic             last_dac, last_adc;
  logic             busy_cycle;
  logic             abort_now;

  assign tick_rise  = tick_i & ~tick_q;
  assign last_dac   = (idx == IDX_W'(DAC_CH - 1));
  assign last_adc   = (idx == IDX_W'(ADC_CH - 1));
  assign busy_cycle = (state != ST_IDLE);
  assign abort_now  = (state == ST_WAIT) && !conv_done_i && tmo_hit_i;

  always_comb begin
    state_nx = state;
    idx_nx   = idx;
    unique case (state)
      ST_IDLE:  if (tick_rise) state_nx = ST_START;
      ST_START: begin state_nx = ST_DACW; idx_nx = '0; end
      ST_DACW: begin
        if (last_dac) begin state_nx = ST_LOAD; idx_nx = '0; end
        else          idx_nx = idx + IDX_W'(1);
      end
      ST_LOAD:  state_nx = ST_WAIT;
      ST_WAIT: begin
        if (conv_done_i)    begin state_nx = ST_READ; idx_nx = '0; end
        else if (tmo_hit_i) state_nx = ST_IDLE;
      end
      ST_READ: begin
        if (last_adc) begin state_nx = ST_DONE; idx_nx = '0; end
        else          idx_nx = idx + IDX_W'(1);
      end
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      tick_q    <= 1'b0;
      overrun_o <= 1'b0;
      tmo_err_o <= 1'b0;
    end else begin
      state  <= state_nx;
      idx    <= idx_nx;
      tick_q <= tick_i;
      if (tick_rise && busy_cycle) overrun_o <= 1'b1;
      else if (flag_clr_i)         overrun_o <= 1'b0;
      if (abort_now)               tmo_err_o <= 1'b1;
      else if (flag_clr_i)         tmo_err_o <= 1'b0;
    end
  end

  always_comb begin
    conv_start_o = (state == ST_START);
    wr_stb_o     = (state == ST_DACW);
    rd_stb_o     = (state == ST_READ);
    dac_load_o   = (state == ST_LOAD);
    ready_o      = (state == ST_DONE);
    wait_o       = (state == ST_WAIT);
    buf_idx_o    = idx[ADC_IW-1:0];
    addr_o       = '0;
    wr_data_o    = '0;
    if (state == ST_DACW) begin
      addr_o    = dac_word(32'(idx));
      wr_data_o = dac_arr[idx[DAC_IW-1:0]];
    end else if (state == ST_READ) begin
      addr_o    = adc_word(32'(idx));
    end
  end

  // R1: convert-start is a single-cycle pulse caused by a rising tick
  p_conv_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  p_conv_from_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> $past(tick_rise));

  // R2: load strobe follows the write to the last DAC word
  p_load_after_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load_o |-> ($past(wr_stb_o) && $past(addr_o) == dac_word(DAC_CH - 1)));

  // R4: readout opens only after both busy lines were seen clear
  p_read_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o && !$past(rd_stb_o)) |-> $past(conv_done_i));

  // R6: ready follows the read of the last result word
  p_ready_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> ($past(rd_stb_o) && $past(addr_o) == adc_word(ADC_CH - 1)));

  // R7: overrun holds until cleared
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !flag_clr_i) |=> overrun_o);

  // R8: an abort leaves no read and no ready behind
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> (!rd_stb_o && !ready_o && $past(wait_o)));

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DAC_CH = 4,
  parameter int unsigned ADC_CH = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      busy_a_i,
  input  logic                      busy_b_i,
  input  logic [DATA_W-1:0]         rd_data_i,
  input  logic [DAC_CH*DATA_W-1:0]  dac_vals_i,
  input  logic [TMO_W-1:0]          tmo_limit_i,
  input  logic                      flag_clr_i,
  output logic                      conv_start_o,
  output logic                      sel_adc_a_o,
  output logic                      sel_adc_b_o,
  output logic                      sel_dac_o,
  output logic                      rd_stb_o,
  output logic                      wr_stb_o,
  output logic [BUS_AW-1:0]         addr_o,
  output logic [DATA_W-1:0]         wr_data_o,
  output logic                      dac_load_o,
  output logic                      buf_we_o,
  output logic [$clog2(ADC_CH)-1:0] buf_idx_o,
  output logic [DATA_W-1:0]         buf_data_o,
  output logic                      ready_o,
  output logic                      overrun_o,
  output logic                      tmo_err_o
);

  logic conv_done;
  logic tmo_hit;
  logic wait_st;

  acq_busy_timer #(.TMO_W(TMO_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_a_i   (busy_a_i),
    .busy_b_i   (busy_b_i),
    .wait_i     (wait_st),
    .limit_i    (tmo_limit_i),
    .conv_done_o(conv_done),
    .tmo_hit_o  (tmo_hit)
  );

  acq_fsm #(.DATA_W(DATA_W), .DAC_CH(DAC_CH), .ADC_CH(ADC_CH)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .conv_done_i (conv_done),
    .tmo_hit_i   (tmo_hit),
    .flag_clr_i  (flag_clr_i),
    .dac_vals_i  (dac_vals_i),
    .conv_start_o(conv_start_o),
    .wr_stb_o    (wr_stb_o),
    .rd_stb_o    (rd_stb_o),
    .addr_o      (addr_o),
    .wr_data_o   (wr_data_o),
    .dac_load_o  (dac_load_o),
    .buf_idx_o   (buf_idx_o),
    .ready_o     (ready_o),
    .wait_o      (wait_st),
    .overrun_o   (overrun_o),
    .tmo_err_o   (tmo_err_o)
  );

  acq_decode u_decode (
    .addr_i     (addr_o),
    .rd_i       (rd_stb_o),
    .wr_i       (wr_stb_o),
    .sel_adc_a_o(sel_adc_a_o),
    .sel_adc_b_o(sel_adc_b_o),
    .sel_dac_o  (sel_dac_o)
  );

  // each read word goes straight to the sample buffer
  assign buf_we_o   = rd_stb_o;
  assign buf_data_o = rd_data_i;

  // R3: every read lands on one ADC, every write on the DAC
  p_rd_hits_adc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> ((sel_adc_a_o ^ sel_adc_b_o) && !sel_dac_o));
  p_wr_hits_dac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (sel_dac_o && !sel_adc_a_o && !sel_adc_b_o));
  // R9: with no strobe the bus is parked on a reserved word
  p_idle_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb_o || wr_stb_o) |-> (!sel_adc_a_o && !sel_adc_b_o && !sel_dac_o));

endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb_top;

  localparam int DW = 16, NDAC = 4, NADC = 8, TW = 16;
  localparam logic [2:0] K_CONV = 3'd0, K_WR = 3'd1, K_LOAD = 3'd2, K_RD = 3'd3, K_RDY = 3'd4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, busy_a, busy_b, flag_clr;
  logic [TW-1:0] limit;
  logic [NDAC*DW-1:0] dac_vals;
  logic [7:0] epoch;
  wire  [DW-1:0] rd_data;

  logic conv, sel_a, sel_b, sel_d, rd_stb, wr_stb, load, buf_we, ready, ovr, terr;
  logic [3:0] addr;
  logic [DW-1:0] wr_data, buf_data;
  logic [2:0] buf_idx;

  // ADC model: each word is tagged with the acquisition epoch and its address
  assign rd_data = {epoch, 4'hA, addr};

  acq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .busy_a_i(busy_a), .busy_b_i(busy_b),
    .rd_data_i(rd_data), .dac_vals_i(dac_vals), .tmo_limit_i(limit), .flag_clr_i(flag_clr),
    .conv_start_o(conv), .sel_adc_a_o(sel_a), .sel_adc_b_o(sel_b), .sel_dac_o(sel_d),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .addr_o(addr), .wr_data_o(wr_data),
    .dac_load_o(load), .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
    .ready_o(ready), .overrun_o(ovr), .tmo_err_o(terr)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [2:0]  idx;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic string req_of(input logic [2:0] k);
    case (k)
      K_CONV:  return "R1 convert start";
      K_WR:    return "R2 dac write";
      K_LOAD:  return "R2 dac load";
      K_RD:    return "R5 result read";
      default: return "R6 ready";
    endcase
  endfunction

  // driver side: queue the bus events one acquisition must produce
  task automatic push_cycle(input bit full);
    exp_t e;
    e = '0; e.kind = K_CONV; exp_q.push_back(e);
    for (int i = 0; i < NDAC; i++) begin
      e = '0; e.kind = K_WR; e.addr = 4'(12 + i); e.data = dac_vals[i*DW +: DW];
      exp_q.push_back(e);
    end
    e = '0; e.kind = K_LOAD; exp_q.push_back(e);
    if (full) begin
      for (int k = 0; k < NADC; k++) begin
        e = '0; e.kind = K_RD; e.addr = 4'(4 + k); e.data = {epoch, 4'hA, 4'(4 + k)};
        e.idx = 3'(k);
        exp_q.push_back(e);
      end
      e = '0; e.kind = K_RDY; exp_q.push_back(e);
    end
  endtask

  // monitor side: pop and compare every bus event
  always @(negedge clk) begin : mon
    int nev;
    exp_t e;
    logic [2:0] kind;
    if (rst_n && !done) begin
      nev = int'(conv) + int'(wr_stb) + int'(load) + int'(rd_stb) + int'(ready);
      kind = conv ? K_CONV : wr_stb ? K_WR : load ? K_LOAD : rd_stb ? K_RD : K_RDY;
      if (nev > 1) chk(1'b0, "R2 one event per cycle", nev, 1);
      else if (nev == 1) begin
        if (exp_q.size() == 0) chk(1'b0, {req_of(kind), " unexpected event"}, int'(kind), 7);
        else begin
          e = exp_q.pop_front();
          chk(kind == e.kind, {req_of(e.kind), " event kind"}, int'(kind), int'(e.kind));
          if (kind == K_WR && e.kind == K_WR) begin
            chk(addr == e.addr, "R2 write address", int'(addr), int'(e.addr));
            chk(wr_data == e.data, "R2 write data", int'(wr_data), int'(e.data));
            chk(sel_d && !sel_a && !sel_b, "R3 dac select on write",
                int'({sel_a, sel_b, sel_d}), 1);
          end
          if (kind == K_RD && e.kind == K_RD) begin
            chk(addr == e.addr, "R5 read address", int'(addr), int'(e.addr));
            chk(buf_we && buf_idx == e.idx, "R5 buffer slot", int'({buf_we, buf_idx}),
                int'({1'b1, e.idx}));
            chk(buf_data == e.data, "R5 buffer data", int'(buf_data), int'(e.data));
            chk({sel_a, sel_b, sel_d} == ((e.addr < 4'd8) ? 3'b100 : 3'b010),
                "R3 adc select on read", int'({sel_a, sel_b, sel_d}),
                int'((e.addr < 4'd8) ? 3'b100 : 3'b010));
          end
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    chk(!conv && !rd_stb && !wr_stb && !load && !ready, {tag, " strobes"},
        int'({conv, rd_stb, wr_stb, load, ready}), 0);
    chk(addr == 4'd0 && !sel_a && !sel_b && !sel_d, {tag, " bus parked"},
        int'({sel_a, sel_b, sel_d, addr}), 0);
    chk(!ovr && !terr, {tag, " flags"}, int'({ovr, terr}), 0);
  endtask

  initial begin
    rst_n = 0; tick = 0; busy_a = 0; busy_b = 0; flag_clr = 0; limit = 16'd100;
    dac_vals = 64'h1111_2222_3333_4444; epoch = 8'h01;
    step(3);
    check_idle("R9 in reset");
    rst_n = 1;
    step(2);
    check_idle("R9 idle after reset");

    // A: tick held high, busy_a clears first (R1 R2 R4 R5 R6)
    dac_vals = 64'hBEEF_0F0F_8000_7FFF; epoch = 8'h11;
    push_cycle(1);
    tick = 1; busy_a = 1; busy_b = 1;       // n0
    step(9); busy_a = 0;                     // n9
    step(1);
    chk(!rd_stb, "R4 no read while one busy high", int'(rd_stb), 0);
    busy_b = 0;                              // n10
    step(1);
    chk(rd_stb && addr == 4'd4, "R4 first read after release", int'({rd_stb, addr}), 'h14);
    tick = 0;
    step(10);
    chk(exp_q.size() == 0, "R6 all events seen", exp_q.size(), 0);
    chk(!ovr, "R7 held tick no overrun", int'(ovr), 0);

    // B: busy_b clears first, second tick during wait (R4 R7)
    dac_vals = 64'h0001_FFFF_A5A5_0000; epoch = 8'h22;
    push_cycle(1);
    tick = 1; busy_a = 1; busy_b = 1;       // n0
    step(2); tick = 0;
    step(6); tick = 1;                       // n8
    step(1);
    chk(ovr, "R7 overrun set", int'(ovr), 1);
    busy_b = 0;                              // n9
    step(1); tick = 0;
    chk(!rd_stb, "R4 busy_a alone blocks read", int'(rd_stb), 0);
    busy_a = 0;                              // n10
    step(1);
    chk(rd_stb && addr == 4'd4, "R4 read after both clear", int'({rd_stb, addr}), 'h14);
    step(10);
    chk(exp_q.size() == 0, "R7 no queued acquisition", exp_q.size(), 0);
    chk(ovr, "R7 overrun sticky", int'(ovr), 1);
    flag_clr = 1;
    step(1); flag_clr = 0;
    chk(!ovr, "R7 overrun cleared", int'(ovr), 0);

    // C: busy never raised, readout right after first wait cycle (R4)
    dac_vals = 64'h0002_0004_0008_0010; epoch = 8'h33;
    push_cycle(1);
    tick = 1;                                // n0
    step(8);
    chk(rd_stb && addr == 4'd4, "R4 immediate readout", int'({rd_stb, addr}), 'h14);
    tick = 0;
    step(13);
    chk(exp_q.size() == 0, "R5 all reads seen", exp_q.size(), 0);

    // D: timeout with limit 4 (R8)
    limit = 16'd4; epoch = 8'h44;
    push_cycle(0);
    tick = 1; busy_a = 1; busy_b = 1;       // n0
    step(2); tick = 0;
    step(8);                                 // n10
    chk(!terr, "R8 no error within limit", int'(terr), 0);
    step(1);                                 // n11
    chk(terr && !rd_stb, "R8 error after limit", int'({terr, rd_stb}), 2);
    step(11);
    chk(exp_q.size() == 0, "R8 no reads or ready after abort", exp_q.size(), 0);
    chk(terr, "R8 error sticky", int'(terr), 1);
    busy_a = 0; busy_b = 0; flag_clr = 1;
    step(1); flag_clr = 0;
    chk(!terr, "R8 error cleared", int'(terr), 0);

    // E: release in the last allowed wait cycle (R8 boundary)
    dac_vals = 64'h7777_6666_5555_4444; epoch = 8'h55;
    push_cycle(1);
    tick = 1; busy_a = 1; busy_b = 1;       // n0
    step(2); tick = 0;
    step(8); busy_a = 0; busy_b = 0;        // n10
    step(1);
    chk(rd_stb && !terr, "R8 release at limit reads", int'({rd_stb, terr}), 2);
    step(10);
    chk(exp_q.size() == 0, "R6 boundary acquisition complete", exp_q.size(), 0);
    check_idle("R9 idle at end");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule